// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block multiplies a signed fixed-point activation by a signed fixed-point weight and adds the result into a running sum. It is meant for a quantized inference datapath. Both operands and the accumulator share one format. The parameter `W` sets the total width and `IB` sets the number of integer bits, with the sign bit counted among them. The remaining `FB = W - IB` bits are fractional.

The full-precision product has `2*FB` fractional bits. It is narrowed back to `FB` fractional bits and then added into the accumulator. Two run-time mode inputs control the arithmetic:
- `rnd_mode` chooses between round-to-nearest and plain truncation for the narrowing step.
- `sat_mode` chooses between clamping to the format extremes and two's-complement wraparound. The wrap setting exists so the two behaviours can be compared.

A clear strobe restarts the sum. Each accepted input is reported one cycle later on `out_valid`. A sticky flag records that a result has left the representable range.

Top module: `fxmac`

## Requirements
- R1: The accumulator output `acc_out` is a signed W-bit value with FB = W - IB fractional bits. Each accepted input adds the product `act * wgt`, both in that same format, after it is narrowed by FB bits. Example with W=10, IB=7: 62.5 * 1.0 loads raw 500.
- R2: With `rnd_mode` = 1, narrowing rounds to nearest and resolves exact halves away from zero. For example, 1.5 LSB becomes 2 and -0.5 LSB becomes -1. With `rnd_mode` = 0 it truncates toward minus infinity, so -1.25 LSB becomes -2.
- R3: With `sat_mode` = 1, any narrowed product or sum above the largest value is replaced by the largest value, and any result below the most negative value is replaced by the most negative value. Example with W=10, IB=7: 62.5 + 2.0 gives 63.875 (raw 511).
- R4: With `sat_mode` = 0, results wrap modulo 2^W. Example with W=10, IB=7: 62.5 + 2.0 gives -63.5 (raw -508).
- R5: The increment added by rounding is itself subject to the clamp or the wrap. For a product of 511.5 LSB with W=10, rounding gives 511 when saturating and -512 when wrapping; truncation gives 511 with no overflow.
- R6: `clr` alone zeroes the accumulator and the overflow flag. When `clr` and `in_valid` are high together, the sum restarts from zero, so the accumulator takes the narrowed product alone.
- R7: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and `acc_out` then shows the updated sum. Without `in_valid` or `clr`, `acc_out` holds its value and `out_valid` is low.
- R8: `ovf` is set when a narrowed product or a sum falls outside the representable range, in either mode. It stays high until a clear.
- R9: After reset, `acc_out` = 0, `out_valid` = 0 and `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Restart the running sum and clear the flag |
| in_valid | input | 1 | Accept `act` and `wgt` this cycle |
| sat_mode | input | 1 | 1 = clamp, 0 = wrap |
| rnd_mode | input | 1 | 1 = round to nearest, 0 = truncate |
| act | input | W | Signed activation |
| wgt | input | W | Signed weight |
| acc_out | output | W | Running sum |
| out_valid | output | 1 | Sum updated by the previous accepted input |
| ovf | output | 1 | Sticky out-of-range flag |

## Verification
The bench builds a main instance with W=10, IB=7 (three fractional bits). In this format the 62.5 + 2.0 case reaches both extremes, and rounding halves of one LSB can be formed exactly. A second instance with W=4, IB=1 is the narrowest useful format, with 4-bit operands and an 8-bit product. There, the product of the two most negative operands overflows on narrowing alone, and a half-LSB rounding case fits in three fractional bits.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
  typedef struct packed {
    logic sat;   // 1: clamp to format limits, 0: wrap
    logic rnd;   // 1: round half away from zero, 0: floor
  } fxmac_mode_t;
endpackage

// File: rtl/fxmac_requant.sv
module fxmac_requant
  import fxmac_pkg::*;
#(
  parameter int W  = 10,
  parameter int FB = 3
) (
  input  logic signed [2*W-1:0] prod,
  input  fxmac_mode_t           mode,
  output logic signed [W-1:0]   q,
  output logic                  oor
);
  localparam int PW = 2 * W;
  localparam int EW = PW + 2;
  localparam logic signed [EW-1:0] MAXV = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = {{(EW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [W-1:0]  MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  MINW = {1'b1, {(W-1){1'b0}}};

  logic signed [EW-1:0] pe;
  logic signed [EW-1:0] res;
  logic                 hi, lo;

  assign pe = {{2{prod[PW-1]}}, prod};

  generate
    if (FB > 0) begin : g_frac
      localparam logic signed [EW-1:0] HALF = EW'(1) << (FB - 1);
      logic                 neg;
      logic signed [EW-1:0] mag, magr;
      always_comb begin
        neg  = pe[EW-1];
        mag  = neg ? -pe : pe;
        magr = (mag + HALF) >>> FB;
        if (mode.rnd) res = neg ? -magr : magr;
        else          res = pe >>> FB;
      end
    end else begin : g_int
      assign res = pe;
    end
  endgenerate

  always_comb begin
    hi  = res > MAXV;
    lo  = res < MINV;
    oor = hi | lo;
    if (mode.sat && hi)      q = MAXW;
    else if (mode.sat && lo) q = MINW;
    else                     q = res[W-1:0];
  end
endmodule

// File: rtl/fxmac_sat_add.sv
module fxmac_sat_add #(
  parameter int W = 10
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  input  logic                sat,
  output logic signed [W-1:0] s,
  output logic                oor
);
  localparam logic signed [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] wide;
  logic              hi, lo;

  always_comb begin
    wide = {a[W-1], a} + {b[W-1], b};
    hi   = ~wide[W] &  wide[W-1];
    lo   =  wide[W] & ~wide[W-1];
    oor  = hi | lo;
    if (sat && hi)      s = MAXW;
    else if (sat && lo) s = MINW;
    else                s = wide[W-1:0];
  end
endmodule

// File: rtl/fxmac.sv
module fxmac
  import fxmac_pkg::*;
#(
  parameter int W  = 10,
  parameter int IB = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_valid,
  input  logic                sat_mode,
  input  logic                rnd_mode,
  input  logic signed [W-1:0] act,
  input  logic signed [W-1:0] wgt,
  output logic signed [W-1:0] acc_out,
  output logic                out_valid,
  output logic                ovf
);
  localparam int FB = W - IB;

  fxmac_mode_t          mode;
  logic signed [2*W-1:0] prod;
  logic signed [W-1:0]  term, base, sum;
  logic                 term_oor, sum_oor;
  logic signed [W-1:0]  acc_q, acc_d;
  logic                 ovf_q, ovf_d, vld_q, vld_d;
  logic                 acc_en;

  assign mode.sat = sat_mode;
  assign mode.rnd = rnd_mode;
  assign prod     = act * wgt;

  fxmac_requant #(.W(W), .FB(FB)) u_requant (
    .prod (prod),
    .mode (mode),
    .q    (term),
    .oor  (term_oor)
  );

  fxmac_sat_add #(.W(W)) u_add (
    .a   (base),
    .b   (term),
    .sat (sat_mode),
    .s   (sum),
    .oor (sum_oor)
  );

  // next state
  always_comb begin
    base   = clr ? '0 : acc_q;
    acc_en = in_valid | clr;
    vld_d  = in_valid;
    if (in_valid) begin
      acc_d = sum;
      ovf_d = (~clr & ovf_q) | term_oor | sum_oor;
    end else begin
      acc_d = '0;
      ovf_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (acc_en) begin
        acc_q <= acc_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign acc_out   = acc_q;
  assign out_valid = vld_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/fxmac_chk.sv
module fxmac_chk #(
  parameter int W = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic                in_valid,
  input logic signed [W-1:0] acc_out,
  input logic                out_valid,
  input logic                ovf
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                   // R7
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                 // R7
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(acc_out));                 // R7
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> (acc_out == '0 && !ovf));           // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);                                    // R8
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !$rose(ovf));                                // R8
endmodule

bind fxmac fxmac_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .in_valid  (in_valid),
  .acc_out   (acc_out),
  .out_valid (out_valid),
  .ovf       (ovf)
);

// File: tb/fxmac_tb.sv
`timescale 1ns/1ps
module fxmac_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  // main instance: W=10, IB=7
  logic clr, in_valid, sat_mode, rnd_mode;
  logic signed [9:0] act, wgt, acc_out;
  logic out_valid, ovf;

  fxmac #(.W(10), .IB(7)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .sat_mode(sat_mode), .rnd_mode(rnd_mode), .act(act), .wgt(wgt),
    .acc_out(acc_out), .out_valid(out_valid), .ovf(ovf)
  );

  // narrow instance: W=4, IB=1
  logic s_clr, s_in_valid;
  logic signed [3:0] s_act, s_wgt, s_acc;
  logic s_valid, s_ovf;

  fxmac #(.W(4), .IB(1)) u_small (
    .clk(clk), .rst_n(rst_n), .clr(s_clr), .in_valid(s_in_valid),
    .sat_mode(1'b1), .rnd_mode(1'b1), .act(s_act), .wgt(s_wgt),
    .acc_out(s_acc), .out_valid(s_valid), .ovf(s_ovf)
  );

  typedef struct packed {
    logic clr; logic sat; logic rnd;
    logic signed [9:0] a; logic signed [9:0] w;
    logic signed [9:0] e; logic eo;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT[NV] = '{
    '{1'b1, 1'b1, 1'b1,  10'sd500,  10'sd8,   10'sd500, 1'b0},  // R1 load 62.5
    '{1'b0, 1'b1, 1'b1,  10'sd16,   10'sd8,   10'sd511, 1'b1},  // R3 +2.0 clamps
    '{1'b1, 1'b0, 1'b1,  10'sd500,  10'sd8,   10'sd500, 1'b0},  // R6 restart
    '{1'b0, 1'b0, 1'b1,  10'sd16,   10'sd8,  -10'sd508, 1'b1},  // R4 +2.0 wraps
    '{1'b1, 1'b1, 1'b1,  10'sd4,    10'sd3,   10'sd2,   1'b0},  // R2 R6 1.5 -> 2
    '{1'b1, 1'b1, 1'b0,  10'sd4,    10'sd3,   10'sd1,   1'b0},  // R2 floor 1.5
    '{1'b1, 1'b1, 1'b1, -10'sd5,    10'sd2,  -10'sd1,   1'b0},  // R2 -1.25 -> -1
    '{1'b1, 1'b1, 1'b0, -10'sd5,    10'sd2,  -10'sd2,   1'b0},  // R2 floor -1.25
    '{1'b1, 1'b1, 1'b1, -10'sd4,    10'sd1,  -10'sd1,   1'b0},  // R2 -0.5 -> -1
    '{1'b1, 1'b1, 1'b1, -10'sd512, -10'sd512, 10'sd511, 1'b1},  // R3 product clamp
    '{1'b1, 1'b0, 1'b1, -10'sd512, -10'sd512, 10'sd0,   1'b1},  // R4 product wrap
    '{1'b1, 1'b1, 1'b1,  10'sd372,  10'sd11,  10'sd511, 1'b1},  // R5 round clamps
    '{1'b1, 1'b0, 1'b1,  10'sd372,  10'sd11, -10'sd512, 1'b1},  // R5 round wraps
    '{1'b1, 1'b1, 1'b0,  10'sd372,  10'sd11,  10'sd511, 1'b0},  // R5 floor fits
    '{1'b1, 1'b1, 1'b1, -10'sd512,  10'sd8,  -10'sd512, 1'b0},  // R3 load min
    '{1'b0, 1'b1, 1'b1, -10'sd8,    10'sd8,  -10'sd512, 1'b1},  // R3 low clamp
    '{1'b0, 1'b1, 1'b1,  10'sd8,    10'sd8,  -10'sd504, 1'b1},  // R8 sticky
    '{1'b0, 1'b0, 1'b0,  10'sd3,    10'sd3,  -10'sd503, 1'b1}   // R8 sticky
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; sat_mode = 1'b1; rnd_mode = 1'b1;
    act = '0; wgt = '0;
    s_clr = 1'b0; s_in_valid = 1'b0; s_act = '0; s_wgt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 acc", int'(acc_out), 0);
    check("R9 valid", int'(out_valid), 0);
    check("R9 ovf", int'(ovf), 0);

    for (int i = 0; i < NV; i++) begin
      clr = VT[i].clr; sat_mode = VT[i].sat; rnd_mode = VT[i].rnd;
      act = VT[i].a; wgt = VT[i].w; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; clr = 1'b0;
      check($sformatf("R1 vec%0d acc", i), int'(acc_out), int'(VT[i].e));
      check($sformatf("R8 vec%0d ovf", i), int'(ovf), int'(VT[i].eo));
      check($sformatf("R7 vec%0d valid", i), int'(out_valid), 1);
    end

    // R7: idle cycle holds the sum and drops valid
    act = 10'sd100; wgt = 10'sd100;
    @(negedge clk);
    check("R7 hold acc", int'(acc_out), -503);
    check("R7 idle valid", int'(out_valid), 0);
    check("R8 hold ovf", int'(ovf), 1);

    // R6: clear alone
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R6 clr acc", int'(acc_out), 0);
    check("R6 clr ovf", int'(ovf), 0);
    check("R6 clr valid", int'(out_valid), 0);

    // narrow format W=4, IB=1
    s_clr = 1'b1; s_in_valid = 1'b1; s_act = -4'sd8; s_wgt = -4'sd8;
    @(negedge clk);
    check("R3 narrow clamp", int'(s_acc), 7);
    check("R8 narrow ovf", int'(s_ovf), 1);
    s_act = 4'sd7; s_wgt = 4'sd7;
    @(negedge clk);
    check("R1 narrow 49/8", int'(s_acc), 6);
    check("R6 narrow ovf cleared", int'(s_ovf), 0);
    s_act = 4'sd3; s_wgt = 4'sd4;
    @(negedge clk);
    s_in_valid = 1'b0; s_clr = 1'b0;
    check("R2 narrow half", int'(s_acc), 2);
    check("R7 narrow valid", int'(s_valid), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule